// File: doc/BRIEF.md
# Sector Lock Map with Bank Decode

This block keeps the write-lock state of a flash array whose sectors are not all the same size. A word address of 22 bits is resolved into a sector number from 0 to 133 and a bank number from 0 to 3. The array has three regions. The bottom 32K words hold four 8K-word sectors. The top 32K words hold another four 8K-word sectors. Everything between them is cut into 32K-word sectors. Each bank covers 1M words and is chosen by the two highest address bits, so the two outer banks are the ones that carry the small sectors.

Each sector has one volatile lock bit. All of these bits come up set (locked) at reset. A lock command pulse acts on the sector that holds its address. Address bit 6 of the command picks the action: a one clears the bit and a zero sets it. Pulses may arrive on back-to-back cycles. An active-low write-protect pin makes every sector read as protected. While the pin is low, the stored bits keep their values.

A query address is decoded combinationally. From it the block gives the sector and bank numbers, a protected flag, a rejection flag for program or erase requests, and the word returned by a protection-verify read.

Top module: `sector_guard`

## Requirements
- R1: The query address decodes to a sector number as follows. Addresses 000000h–007FFFh map to sectors 0–3, 8K words each. From 008000h, the 32K-word sectors are numbered 4 to 129. Addresses 3F8000h–3FFFFFh map to sectors 130–133, 8K words each.
- R2: The bank number equals query address bits 21:20.
- R3: After reset, with the write-protect pin high, every sector reports protected.
- R4: A lock pulse with address bit 6 high clears the lock of the addressed sector. A pulse with bit 6 low sets it. The change shows on the query outputs one cycle after the pulse.
- R5: A lock pulse leaves the lock state of every other sector unchanged. This includes sectors that are neighbours in address.
- R6: While the write-protect pin is low, every sector reports protected. When the pin returns high, each sector again reports its stored lock bit.
- R7: The verify word is 0001h when query address bits 7:0 equal 02h and the sector is protected. It is 0000h when the sector is unprotected, and 0000h whenever bits 7:0 differ from 02h.
- R8: The rejection output is high in the same cycle exactly when the request input is high and the queried sector is protected.
- R9: A lock pulse to the sector being queried leaves the protected flag at its old value during the pulse cycle.
- R10: Lock pulses on consecutive cycles each take effect, with no restart of the sequence.
- R11: Asserting reset after lock changes sets the lock of every sector again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; locks all sectors |
| lk_pulse | input | 1 | One-cycle lock/unlock command strobe |
| lk_addr | input | 22 | Command address; bit 6 high unlocks |
| wp_n | input | 1 | Write-protect pin; low protects all sectors |
| qry_addr | input | 22 | Address being checked |
| req_valid | input | 1 | Program or erase request to qry_addr |
| qry_sector | output | 8 | Decoded sector number |
| qry_bank | output | 2 | Decoded bank number |
| qry_prot | output | 1 | Queried sector is protected |
| req_reject | output | 1 | Request refused because of protection |
| vfy_word | output | 16 | Protection-verify read value |

## Verification
A lock command and a query can hit the same sector in the same cycle. The query path is combinational from the registered bits, so during the pulse cycle the query must still show the old state. The bench checks this by placing the query on the target sector while the pulse is held. It samples the protected flag in that cycle, and then again after the edge, where the new state must appear. The same check is repeated for the set direction and for back-to-back pulses to sectors at opposite ends of the array.

// File: rtl/sector_guard_pkg.sv
// Package: shared constants for the sector lock map.
// Assumes: verify word is 16 bits wide and carries the protection state in bit 0.
package sector_guard_pkg;
    localparam int VFY_W = 16;
    typedef logic [VFY_W-1:0] vfy_word_t;
    localparam vfy_word_t VFY_LOCKED = 16'h0001;
    localparam vfy_word_t VFY_OPEN   = 16'h0000;
endpackage

// File: rtl/sg_sector_decode.sv
// Module: address to sector/bank decode for a map with small sectors at both ends.
// Assumes: SMALL_CNT small sectors exactly fill one large sector slot at each end.
module sg_sector_decode #(
    parameter int ADDR_W = 22,
    parameter int BIG_W  = 15,
    parameter int SMALL_W = 13,
    parameter int BANK_W = 2,
    parameter int SECT_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sector,
    output logic [BANK_W-1:0] bank
);
    localparam int HI_W      = ADDR_W - BIG_W;
    localparam int SUB_W     = BIG_W - SMALL_W;
    localparam int SMALL_CNT = 1 << SUB_W;
    localparam int BIG_CNT   = (1 << HI_W) - 2;

    logic [HI_W-1:0]  hi;
    logic [SUB_W-1:0] sub;

    // Split the address into large-slot index and small-sector index.
    always_comb begin
        hi  = addr[ADDR_W-1:BIG_W];
        sub = addr[BIG_W-1:SMALL_W];
    end

    // Choose between bottom small, middle large and top small regions.
    always_comb begin
        if (hi == '0)
            sector = SECT_W'(sub);
        else if (hi == '1)
            sector = SECT_W'(SMALL_CNT + BIG_CNT) + SECT_W'(sub);
        else
            sector = SECT_W'(hi) + SECT_W'(SMALL_CNT - 1);
    end

    // Bank is the top address field.
    always_comb bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sg_lock_bits.sv
// Module: one volatile lock flop per sector, set on reset.
// Assumes: wr_sector is always below SECT_CNT.
module sg_lock_bits #(
    parameter int SECT_CNT = 134,
    parameter int SECT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SECT_W-1:0]   wr_sector,
    input  logic                wr_unlock,
    output logic [SECT_CNT-1:0] lock_q
);
    for (genvar i = 0; i < SECT_CNT; i++) begin : g_bit
        // Hold lock bit i; reset locks, a matching write loads the new state.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[i] <= 1'b1;
            else if (wr_en && wr_sector == SECT_W'(i))
                lock_q[i] <= ~wr_unlock;
        end
    end
endmodule

// File: rtl/sg_status.sv
// Module: protection flag, request rejection and verify word for a query.
// Assumes: sector is a valid index; the verify offset sits in address bits 7:0.
module sg_status
    import sector_guard_pkg::*;
#(
    parameter int SECT_CNT = 134,
    parameter int SECT_W = 8,
    parameter logic [7:0] VFY_OFS = 8'h02
) (
    input  logic [SECT_CNT-1:0] lock_q,
    input  logic [SECT_W-1:0]   sector,
    input  logic                wp_n,
    input  logic [7:0]          low_byte,
    input  logic                req_valid,
    output logic                prot,
    output logic                req_reject,
    output vfy_word_t           vfy_word
);
    // The pin overrides the stored bit when low.
    always_comb prot = ~wp_n | lock_q[sector];

    // Refuse program or erase to a protected sector.
    always_comb req_reject = req_valid & prot;

    // Verify read value only at the verify offset.
    always_comb begin
        if (low_byte == VFY_OFS && prot)
            vfy_word = VFY_LOCKED;
        else
            vfy_word = VFY_OPEN;
    end
endmodule

// File: rtl/sector_guard.sv
// Module: sector lock map top; decodes command and query addresses, keeps lock bits.
// Assumes: lk_pulse is a single-cycle strobe from an external command decoder.
module sector_guard
    import sector_guard_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BIG_W = 15,
    parameter int SMALL_W = 13,
    parameter int BANK_W = 2,
    parameter int UNLOCK_BIT = 6,
    parameter logic [7:0] VFY_OFS = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_pulse,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] qry_addr,
    input  logic              req_valid,
    output logic [7:0]        qry_sector,
    output logic [BANK_W-1:0] qry_bank,
    output logic              qry_prot,
    output logic              req_reject,
    output logic [15:0]       vfy_word
);
    localparam int SMALL_CNT = 1 << (BIG_W - SMALL_W);
    localparam int SECT_CNT  = 2 * SMALL_CNT + (1 << (ADDR_W - BIG_W)) - 2;
    localparam int SECT_W    = $clog2(SECT_CNT);

    logic [SECT_W-1:0]   lk_sector;
    logic [BANK_W-1:0]   lk_bank;
    logic [SECT_W-1:0]   q_sector;
    logic [SECT_CNT-1:0] lock_q;
    vfy_word_t           vfy_int;

    sg_sector_decode #(.ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
                       .BANK_W(BANK_W), .SECT_W(SECT_W)) u_lk_dec (
        .addr(lk_addr), .sector(lk_sector), .bank(lk_bank));

    sg_sector_decode #(.ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
                       .BANK_W(BANK_W), .SECT_W(SECT_W)) u_q_dec (
        .addr(qry_addr), .sector(q_sector), .bank(qry_bank));

    sg_lock_bits #(.SECT_CNT(SECT_CNT), .SECT_W(SECT_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .wr_en(lk_pulse), .wr_sector(lk_sector),
        .wr_unlock(lk_addr[UNLOCK_BIT]), .lock_q(lock_q));

    sg_status #(.SECT_CNT(SECT_CNT), .SECT_W(SECT_W), .VFY_OFS(VFY_OFS)) u_stat (
        .lock_q(lock_q), .sector(q_sector), .wp_n(wp_n), .low_byte(qry_addr[7:0]),
        .req_valid(req_valid), .prot(qry_prot), .req_reject(req_reject),
        .vfy_word(vfy_int));

    // Widen the sector number and pass the verify word out.
    always_comb begin
        qry_sector = 8'(q_sector);
        vfy_word   = vfy_int;
    end
endmodule

// File: rtl/sector_guard_chk.sv
// Module: assertion checker bound to sector_guard.
// Assumes: rst_n is driven low before the first clock edge.
module sector_guard_chk #(
    parameter int ADDR_W = 22,
    parameter int SECT_CNT = 134,
    parameter int SECT_W = 8,
    parameter int UNLOCK_BIT = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_pulse,
    input logic [ADDR_W-1:0]   lk_addr,
    input logic                wp_n,
    input logic                req_valid,
    input logic                qry_prot,
    input logic                req_reject,
    input logic [15:0]         vfy_word,
    input logic [7:0]          qry_sector,
    input logic [SECT_W-1:0]   lk_sector,
    input logic [SECT_CNT-1:0] lock_q
);
    AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        qry_sector < 8'(SECT_CNT)); // R1
    AST_RESET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&lock_q)); // R3
    AST_LOCK_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pulse |=> lock_q[$past(lk_sector)] == !$past(lk_addr[UNLOCK_BIT])); // R4
    AST_LOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_pulse |=> $stable(lock_q)); // R5
    AST_WP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> qry_prot); // R6
    AST_VFY_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (vfy_word != 16'h0000) |-> (qry_prot && vfy_word == 16'h0001)); // R7
    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject == (req_valid && qry_prot)); // R8
endmodule

bind sector_guard sector_guard_chk #(
    .ADDR_W(ADDR_W), .SECT_CNT(SECT_CNT), .SECT_W(SECT_W), .UNLOCK_BIT(UNLOCK_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pulse(lk_pulse), .lk_addr(lk_addr), .wp_n(wp_n),
    .req_valid(req_valid), .qry_prot(qry_prot), .req_reject(req_reject),
    .vfy_word(vfy_word), .qry_sector(qry_sector), .lk_sector(lk_sector),
    .lock_q(lock_q)
);

// File: tb/test_sector_guard.sv
module test_sector_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_pulse = 1'b0;
    logic [21:0] lk_addr = '0;
    logic        wp_n = 1'b1;
    logic [21:0] qry_addr = '0;
    logic        req_valid = 1'b0;
    logic [7:0]  qry_sector;
    logic [1:0]  qry_bank;
    logic        qry_prot;
    logic        req_reject;
    logic [15:0] vfy_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sector_guard i_sector_guard (
        .clk(clk), .rst_n(rst_n), .lk_pulse(lk_pulse), .lk_addr(lk_addr),
        .wp_n(wp_n), .qry_addr(qry_addr), .req_valid(req_valid),
        .qry_sector(qry_sector), .qry_bank(qry_bank), .qry_prot(qry_prot),
        .req_reject(req_reject), .vfy_word(vfy_word));

    // {address, expected sector, expected bank}
    localparam logic [31:0] VEC [15] = '{
        {22'h000000, 8'd0,   2'd0}, {22'h001FFF, 8'd0,   2'd0},
        {22'h002000, 8'd1,   2'd0}, {22'h007FFF, 8'd3,   2'd0},
        {22'h008000, 8'd4,   2'd0}, {22'h0FFFFF, 8'd34,  2'd0},
        {22'h100000, 8'd35,  2'd1}, {22'h1FFFFF, 8'd66,  2'd1},
        {22'h200000, 8'd67,  2'd2}, {22'h2FFFFF, 8'd98,  2'd2},
        {22'h300000, 8'd99,  2'd3}, {22'h3F7FFF, 8'd129, 2'd3},
        {22'h3F8000, 8'd130, 2'd3}, {22'h3FA000, 8'd131, 2'd3},
        {22'h3FFFFF, 8'd133, 2'd3}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge; inputs change there.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic query(logic [21:0] a);
        qry_addr = a;
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 R2 R3: decode table, all sectors locked after reset
        foreach (VEC[k]) begin
            query(VEC[k][31:10]);
            chk("R1", 32'(qry_sector), 32'(VEC[k][9:2]));
            chk("R2", 32'(qry_bank), 32'(VEC[k][1:0]));
            chk("R3", 32'(qry_prot), 32'd1);
        end

        // R7: verify word at offset 02h on a locked sector
        query(22'h010002);
        chk("R7", 32'(vfy_word), 32'h0001);

        // R9: unlock sector 5 while querying it; old state during the pulse
        step();
        lk_pulse = 1'b1; lk_addr = 22'h010040;
        query(22'h010002);
        chk("R9", 32'(qry_prot), 32'd1);
        step();
        lk_pulse = 1'b0;
        query(22'h010002);
        chk("R4", 32'(qry_prot), 32'd0);
        chk("R7", 32'(vfy_word), 32'h0000);
        query(22'h008002);
        chk("R5", 32'(qry_prot), 32'd1);
        query(22'h018002);
        chk("R5", 32'(qry_prot), 32'd1);

        // R4 R9: relock sector 5 with bit 6 low
        lk_pulse = 1'b1; lk_addr = 22'h010000;
        query(22'h017F02);
        chk("R9", 32'(qry_prot), 32'd0);
        step();
        lk_pulse = 1'b0;
        query(22'h017F02);
        chk("R4", 32'(qry_prot), 32'd1);

        // R10: back-to-back unlocks of sectors 0 and 133
        lk_pulse = 1'b1; lk_addr = 22'h000040;
        step();
        lk_addr = 22'h3FE040;
        step();
        lk_pulse = 1'b0;
        query(22'h000002);
        chk("R10", 32'(qry_prot), 32'd0);
        query(22'h3FFF02);
        chk("R10", 32'(qry_prot), 32'd0);
        query(22'h002002);
        chk("R5", 32'(qry_prot), 32'd1);

        // R7: protected sector but offset not 02h
        query(22'h008005);
        chk("R7", 32'(vfy_word), 32'h0000);

        // R8: request rejection
        req_valid = 1'b1;
        query(22'h000002);
        chk("R8", 32'(req_reject), 32'd0);
        query(22'h008002);
        chk("R8", 32'(req_reject), 32'd1);
        req_valid = 1'b0;
        query(22'h008002);
        chk("R8", 32'(req_reject), 32'd0);

        // R6: pin low protects an unlocked sector, high restores it
        wp_n = 1'b0;
        req_valid = 1'b1;
        query(22'h000002);
        chk("R6", 32'(qry_prot), 32'd1);
        chk("R6", 32'(vfy_word), 32'h0001);
        chk("R8", 32'(req_reject), 32'd1);
        req_valid = 1'b0;
        step();
        wp_n = 1'b1;
        query(22'h000002);
        chk("R6", 32'(qry_prot), 32'd0);

        // R11: reset relocks everything
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        query(22'h000002);
        chk("R11", 32'(qry_prot), 32'd1);
        query(22'h3FFF02);
        chk("R11", 32'(qry_prot), 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule